// File: doc/BRIEF.md
# UART Character Buffer and Interrupt Controller

This block sits between a register-style host port and the serial transmit and receive engines of a UART. It holds two 16-entry by 8-bit FIFOs. The host fills the transmit FIFO, which the transmit engine drains. The receive engine fills the receive FIFO, which the host drains. Overflow on either side is detected and the offending byte is dropped.

The block turns FIFO depths, configurable thresholds and engine events into eight interrupt sources. Each source has an unqualified raw bit, a per-bit enable, and a masked view. The masked bits are ORed onto one `irq` line. Threshold sources are levels that follow the FIFO depth. Overflow, receive-error and clear-to-send change sources are sticky: software or a FIFO clear removes them. The block also drives a ready-to-send flow-control output from its own receive-depth threshold. It raises a receive timeout when data has sat unread while no new character arrived for a set number of character times.

Top module: `uart_fifo_irq`

## Requirements
- R1: Both FIFOs return bytes in write order. `rd_data` and `tx_char` show the oldest entry without latency. `rx_avail` is high exactly when the receive FIFO holds data, and `tx_valid` is high exactly when the transmit FIFO holds data. A pop of an empty FIFO changes nothing.
- R2: A host write to a full transmit FIFO is dropped and sets source bit 6. A receive push into a full receive FIFO is dropped and sets source bit 3. A pop in the same cycle does not rescue the push.
- R3: Source bit 0 reads 1 while the receive depth is greater than or equal to the receive trigger level.
- R4: Source bit 4 reads 1 while the transmit depth is less than or equal to the transmit trigger level. Source bit 5 reads 1 while the transmit FIFO is empty.
- R5: With `flow_en` low, `rts` is high. With `flow_en` high, `rts` is low while the receive depth is at or above the RTS threshold, and high once the depth drops below it.
- R6: Source bit 1 reads 1 when the receive FIFO is not empty and at least the timeout limit of `char_tick` pulses have occurred since the last receive push. A new push or an empty FIFO returns it to 0.
- R7: Sticky bits 2 (pulse on `rx_err`), 3, 6 and 7 hold until their `irq_clr` bit is pulsed. `clr_rx` also clears bits 2 and 3, and `clr_tx` also clears bit 6. A set event in the same cycle as a clear wins.
- R8: Pulsing `irq_clr` on the level bits 0, 1, 4 and 5 has no effect on them.
- R9: `irq_masked` equals `irq_raw` AND `irq_enable`. `irq` is high exactly when any masked bit is high.
- R10: `clr_rx` and `clr_tx` empty their FIFO in one cycle, taking priority over a push in the same cycle.
- R11: Out of reset, the receive and transmit trigger levels are 8, the RTS threshold is 12 and the timeout limit is 4. A `cfg_we` pulse loads all four at once.
- R12: `cts` passes through a two-stage synchronizer. Any change of level sets sticky bit 7 on the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write into the transmit FIFO |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host pop of the receive FIFO |
| rd_data | output | 8 | Oldest receive byte |
| rx_avail | output | 1 | Receive FIFO not empty |
| rx_push | input | 1 | Receive engine delivers a character |
| rx_char | input | 8 | Received character |
| rx_err | input | 1 | Receive engine framing or parity error pulse |
| tx_pop | input | 1 | Transmit engine takes the oldest byte |
| tx_char | output | 8 | Oldest transmit byte |
| tx_valid | output | 1 | Transmit FIFO not empty |
| char_tick | input | 1 | One pulse per character time |
| cts | input | 1 | Clear-to-send input (asynchronous) |
| rts | output | 1 | Ready-to-send output |
| flow_en | input | 1 | Hardware flow control enable |
| cfg_we | input | 1 | Load the four configuration values |
| cfg_rx_trig | input | 5 | Receive trigger level |
| cfg_tx_trig | input | 5 | Transmit trigger level |
| cfg_rts_trig | input | 5 | RTS depth threshold |
| cfg_to_limit | input | 4 | Timeout limit in character times |
| clr_rx | input | 1 | Receive FIFO clear command |
| clr_tx | input | 1 | Transmit FIFO clear command |
| irq_enable | input | 8 | Per-source enable |
| irq_clr | input | 8 | Per-source clear pulse (sticky bits only) |
| irq_raw | output | 8 | Unqualified source status |
| irq_masked | output | 8 | Enabled source status |
| irq | output | 1 | OR of masked sources |

## Verification
Both FIFOs are driven with short ordered sequences, with fills to exactly one below, at and above each threshold, and with a fill past full. Together these separate a correct depth comparison from an off-by-one, and a dropped overflow byte from one that overwrites stored data. Clear pulses are applied to level bits, to sticky bits alone, and to sticky bits in the same cycle as their set event, which tells a correct set-wins policy from a clear-wins or clear-everything one. Timeout runs stop one tick short of the limit and then cross it, and are then interrupted by a push and by draining, showing that the counter restarts and that the source follows emptiness.

// File: rtl/ufi_pkg.sv
`timescale 1ns/1ps
package ufi_pkg;
    localparam int DATA_W     = 8;
    localparam int FIFO_DEPTH = 16;
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
    localparam int TO_W       = 4;
    localparam int NSRC       = 8;

    typedef enum int unsigned {
        SRC_RX_LVL   = 0,
        SRC_RX_TO    = 1,
        SRC_RX_ERR   = 2,
        SRC_RX_OVF   = 3,
        SRC_TX_LVL   = 4,
        SRC_TX_EMPTY = 5,
        SRC_TX_OVF   = 6,
        SRC_CTS_CHG  = 7
    } src_e;

    typedef logic [NSRC-1:0] src_vec_t;

    function automatic src_vec_t src_bit(input src_e s);
        return src_vec_t'(1) << int'(s);
    endfunction

    localparam src_vec_t STICKY_MASK = src_bit(SRC_RX_ERR) | src_bit(SRC_RX_OVF)
                                     | src_bit(SRC_TX_OVF) | src_bit(SRC_CTS_CHG);

    typedef struct packed {
        logic [CNT_W-1:0] rx_trig;
        logic [CNT_W-1:0] tx_trig;
        logic [CNT_W-1:0] rts_trig;
        logic [TO_W-1:0]  to_limit;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        rx_trig:  CNT_W'(FIFO_DEPTH / 2),
        tx_trig:  CNT_W'(FIFO_DEPTH / 2),
        rts_trig: CNT_W'((FIFO_DEPTH * 3) / 4),
        to_limit: TO_W'(4)
    };
endpackage

// File: rtl/ufi_fifo.sv
`timescale 1ns/1ps
module ufi_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          drop
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign drop    = push && full && !clr;
    assign head    = mem[rp];

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wrap_inc(wp);
            if (do_pop)  rp <= wrap_inc(rp);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push && !clr) |=> (count == CW'(DEPTH)) || $past(pop));
    // R1
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push && !clr) |=> empty);
    // R10
    clr_empty_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> empty);
endmodule

// File: rtl/ufi_rx_timer.sv
`timescale 1ns/1ps
module ufi_rx_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          rx_empty,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    localparam logic [TW-1:0] CNT_MAX = '1;
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart || rx_empty) cnt <= '0;
        else if (tick && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    assign expired = !rx_empty && (cnt >= limit);

    // R6
    to_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (!expired && !tick && !rx_empty) |=> (!expired || limit != $past(limit)));
endmodule

// File: rtl/ufi_irq.sv
`timescale 1ns/1ps
module ufi_irq import ufi_pkg::*; (
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t level,
    input  src_vec_t set_evt,
    input  src_vec_t clr_req,
    input  src_vec_t hw_clr,
    input  src_vec_t enable,
    output src_vec_t raw,
    output src_vec_t masked,
    output logic     irq
);
    src_vec_t sticky_q;

    always_ff @(posedge clk) begin
        if (rst) sticky_q <= '0;
        else     sticky_q <= ((sticky_q & ~(clr_req | hw_clr)) | set_evt) & STICKY_MASK;
    end

    assign raw    = (level & ~STICKY_MASK) | sticky_q;
    assign masked = raw & enable;
    assign irq    = |masked;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (STICKY_MASK[i]) begin : g_stk
            // R7
            sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (raw[i] && !clr_req[i] && !hw_clr[i]) |=> raw[i]);
            // R7
            sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
                set_evt[i] |=> raw[i]);
        end
    end
endmodule

// File: rtl/uart_fifo_irq.sv
`timescale 1ns/1ps
module uart_fifo_irq import ufi_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_avail,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_char,
    input  logic              rx_err,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_char,
    output logic              tx_valid,
    input  logic              char_tick,
    input  logic              cts,
    output logic              rts,
    input  logic              flow_en,
    input  logic              cfg_we,
    input  logic [CNT_W-1:0]  cfg_rx_trig,
    input  logic [CNT_W-1:0]  cfg_tx_trig,
    input  logic [CNT_W-1:0]  cfg_rts_trig,
    input  logic [TO_W-1:0]   cfg_to_limit,
    input  logic              clr_rx,
    input  logic              clr_tx,
    input  logic [NSRC-1:0]   irq_enable,
    input  logic [NSRC-1:0]   irq_clr,
    output logic [NSRC-1:0]   irq_raw,
    output logic [NSRC-1:0]   irq_masked,
    output logic              irq
);
    cfg_t             cfg_q;
    logic [CNT_W-1:0] rx_cnt, tx_cnt;
    logic             rx_empty, tx_empty, rx_drop, tx_drop, to_exp;
    logic             cts_s1, cts_s2, cts_s3;
    src_vec_t         lvl, set_evt, hw_clr;

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= CFG_RESET;
        else if (cfg_we) cfg_q <= '{rx_trig: cfg_rx_trig, tx_trig: cfg_tx_trig,
                                    rts_trig: cfg_rts_trig, to_limit: cfg_to_limit};
    end

    always_ff @(posedge clk) begin
        if (rst) {cts_s1, cts_s2, cts_s3} <= 3'b111;
        else     {cts_s1, cts_s2, cts_s3} <= {cts, cts_s1, cts_s2};
    end

    ufi_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk(clk), .rst(rst), .clr(clr_rx), .push(rx_push), .push_data(rx_char),
        .pop(rd_en), .head(rd_data), .count(rx_cnt), .empty(rx_empty), .drop(rx_drop)
    );

    ufi_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk(clk), .rst(rst), .clr(clr_tx), .push(wr_en), .push_data(wr_data),
        .pop(tx_pop), .head(tx_char), .count(tx_cnt), .empty(tx_empty), .drop(tx_drop)
    );

    ufi_rx_timer #(.TW(TO_W)) u_rx_timer (
        .clk(clk), .rst(rst), .restart(rx_push || clr_rx), .rx_empty(rx_empty),
        .tick(char_tick), .limit(cfg_q.to_limit), .expired(to_exp)
    );

    always_comb begin
        lvl               = '0;
        lvl[SRC_RX_LVL]   = (rx_cnt >= cfg_q.rx_trig);
        lvl[SRC_RX_TO]    = to_exp;
        lvl[SRC_TX_LVL]   = (tx_cnt <= cfg_q.tx_trig);
        lvl[SRC_TX_EMPTY] = tx_empty;

        set_evt              = '0;
        set_evt[SRC_RX_ERR]  = rx_err;
        set_evt[SRC_RX_OVF]  = rx_drop;
        set_evt[SRC_TX_OVF]  = tx_drop;
        set_evt[SRC_CTS_CHG] = cts_s2 ^ cts_s3;

        hw_clr             = '0;
        hw_clr[SRC_RX_ERR] = clr_rx;
        hw_clr[SRC_RX_OVF] = clr_rx;
        hw_clr[SRC_TX_OVF] = clr_tx;
    end

    ufi_irq u_irq (
        .clk(clk), .rst(rst), .level(lvl), .set_evt(set_evt), .clr_req(irq_clr),
        .hw_clr(hw_clr), .enable(irq_enable), .raw(irq_raw), .masked(irq_masked), .irq(irq)
    );

    assign rx_avail = !rx_empty;
    assign tx_valid = !tx_empty;
    assign rts      = flow_en ? (rx_cnt < cfg_q.rts_trig) : 1'b1;

    // R5
    rts_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flow_en && rts && !rx_push && !cfg_we) |=> (rts || !flow_en));
    // R4
    tx_empty_src_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !irq_raw[SRC_TX_EMPTY]);
endmodule

// File: tb/uart_fifo_irq_test.sv
`timescale 1ns/1ps
module uart_fifo_irq_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 0, rd_en = 0, rx_push = 0, rx_err = 0, tx_pop = 0;
    logic [7:0] wr_data = 0, rx_char = 0;
    logic       char_tick = 0, cts = 1, flow_en = 0, cfg_we = 0, clr_rx = 0, clr_tx = 0;
    logic [4:0] cfg_rx_trig = 8, cfg_tx_trig = 8, cfg_rts_trig = 12;
    logic [3:0] cfg_to_limit = 4;
    logic [7:0] irq_enable = 0, irq_clr = 0;
    logic [7:0] rd_data, tx_char, irq_raw, irq_masked;
    logic       rx_avail, tx_valid, rts, irq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    uart_fifo_irq uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .rx_avail(rx_avail), .rx_push(rx_push), .rx_char(rx_char),
        .rx_err(rx_err), .tx_pop(tx_pop), .tx_char(tx_char), .tx_valid(tx_valid),
        .char_tick(char_tick), .cts(cts), .rts(rts), .flow_en(flow_en), .cfg_we(cfg_we),
        .cfg_rx_trig(cfg_rx_trig), .cfg_tx_trig(cfg_tx_trig), .cfg_rts_trig(cfg_rts_trig),
        .cfg_to_limit(cfg_to_limit), .clr_rx(clr_rx), .clr_tx(clr_tx),
        .irq_enable(irq_enable), .irq_clr(irq_clr), .irq_raw(irq_raw),
        .irq_masked(irq_masked), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic push_rx(input logic [7:0] b);
        rx_push = 1; rx_char = b; step(); rx_push = 0;
    endtask

    task automatic pop_rx(output logic [7:0] b);
        b = rd_data; rd_en = 1; step(); rd_en = 0;
    endtask

    task automatic write_tx(input logic [7:0] b);
        wr_en = 1; wr_data = b; step(); wr_en = 0;
    endtask

    task automatic pop_tx(output logic [7:0] b);
        b = tx_char; tx_pop = 1; step(); tx_pop = 0;
    endtask

    task automatic load_cfg(input logic [4:0] rxt, input logic [4:0] txt,
                            input logic [4:0] rtst, input logic [3:0] tol);
        cfg_rx_trig = rxt; cfg_tx_trig = txt; cfg_rts_trig = rtst; cfg_to_limit = tol;
        cfg_we = 1; step(); cfg_we = 0;
    endtask

    task automatic pulse_clr_rx();
        clr_rx = 1; step(); clr_rx = 0;
    endtask

    task automatic t_reset();
        check("R11 reset raw", irq_raw, 8'h30);
        check("R1 reset rx_avail", rx_avail, 0);
        check("R1 reset tx_valid", tx_valid, 0);
        check("R5 reset rts", rts, 1);
        check("R9 reset irq", irq, 0);
    endtask

    task automatic t_rx_order();
        logic [7:0] b;
        push_rx(8'hA5); push_rx(8'h3C); push_rx(8'h0F);
        check("R1 rx_avail set", rx_avail, 1);
        pop_rx(b); check("R1 rx order 0", b, 8'hA5);
        pop_rx(b); check("R1 rx order 1", b, 8'h3C);
        pop_rx(b); check("R1 rx order 2", b, 8'h0F);
        check("R1 rx_avail clear", rx_avail, 0);
        pop_rx(b);
        check("R1 pop empty avail", rx_avail, 0);
        check("R1 pop empty no ovf", irq_raw[3], 0);
        push_rx(8'h77); pop_rx(b);
        check("R1 pointer after empty pop", b, 8'h77);
    endtask

    task automatic t_rx_level();
        for (int i = 0; i < 7; i++) push_rx(8'(i));
        check("R3 depth 7 below trig", irq_raw[0], 0);
        push_rx(8'h07);
        check("R3 depth 8 at trig", irq_raw[0], 1);
        begin logic [7:0] b; pop_rx(b); end
        check("R3 back below trig", irq_raw[0], 0);
        load_cfg(2, 8, 12, 4);
        check("R11 new rx trig", irq_raw[0], 1);
        load_cfg(8, 8, 12, 4);
        pulse_clr_rx();
        check("R10 rx clear", rx_avail, 0);
    endtask

    task automatic t_rx_ovf();
        logic [7:0] b;
        for (int i = 0; i < 16; i++) push_rx(8'h10 + 8'(i));
        check("R2 full no ovf yet", irq_raw[3], 0);
        rx_push = 1; rx_char = 8'hEE; rd_en = 1; step(); rx_push = 0; rd_en = 0;
        check("R2 rx ovf set with pop", irq_raw[3], 1);
        for (int i = 1; i < 16; i++) pop_rx(b);
        check("R2 rx last kept byte", b, 8'h1F);
        check("R2 dropped byte absent", rx_avail, 0);
        check("R7 rx ovf sticky", irq_raw[3], 1);
        irq_clr = 8'h08; step(); irq_clr = 0;
        check("R7 rx ovf cleared", irq_raw[3], 0);
    endtask

    task automatic t_tx();
        logic [7:0] b;
        for (int i = 0; i < 9; i++) write_tx(8'h40 + 8'(i));
        check("R1 tx_valid", tx_valid, 1);
        check("R1 tx head", tx_char, 8'h40);
        check("R4 depth 9 above trig", irq_raw[5:4], 2'b00);
        pop_tx(b);
        check("R4 depth 8 at trig", irq_raw[4], 1);
        for (int i = 9; i < 17; i++) write_tx(8'h40 + 8'(i));
        check("R2 tx full no ovf", irq_raw[6], 0);
        write_tx(8'hFF);
        check("R2 tx ovf set", irq_raw[6], 1);
        for (int i = 1; i < 17; i++) begin
            pop_tx(b);
            check("R1 tx order", b, 8'h40 + 8'(i));
        end
        check("R1 tx drained", tx_valid, 0);
        check("R4 tx empty bit", irq_raw[5], 1);
    endtask

    task automatic t_level_noclr();
        irq_clr = 8'h33; step(); irq_clr = 0;
        check("R8 level bits unchanged", irq_raw & 8'h33, 8'h30);
        check("R7 tx ovf untouched", irq_raw[6], 1);
        clr_tx = 1; step(); clr_tx = 0;
        check("R10 tx clear clears ovf", irq_raw[6], 0);
    endtask

    task automatic t_set_wins();
        rx_err = 1; irq_clr = 8'h04; step(); rx_err = 0; irq_clr = 0;
        check("R7 set wins over clear", irq_raw[2], 1);
        irq_clr = 8'h04; step(); irq_clr = 0;
        check("R7 err cleared", irq_raw[2], 0);
        rx_err = 1; step(); rx_err = 0;
        pulse_clr_rx();
        check("R7 rx clear clears err", irq_raw[2], 0);
    endtask

    task automatic t_rts();
        logic [7:0] b;
        for (int i = 0; i < 12; i++) push_rx(8'(i));
        check("R5 flow off rts high", rts, 1);
        flow_en = 1; step();
        check("R5 depth 12 rts low", rts, 0);
        pop_rx(b);
        check("R5 depth 11 rts high", rts, 1);
        push_rx(8'h55);
        check("R5 depth 12 again low", rts, 0);
        flow_en = 0;
        pulse_clr_rx();
    endtask

    task automatic t_timeout();
        logic [7:0] b;
        load_cfg(8, 8, 12, 3);
        push_rx(8'h01);
        char_tick = 1; step(); step(); char_tick = 0;
        check("R6 two ticks no timeout", irq_raw[1], 0);
        char_tick = 1; step(); char_tick = 0;
        check("R6 third tick timeout", irq_raw[1], 1);
        irq_clr = 8'h02; step(); irq_clr = 0;
        check("R8 timeout not clearable", irq_raw[1], 1);
        push_rx(8'h02);
        check("R6 push restarts", irq_raw[1], 0);
        char_tick = 1; step(); step(); step(); char_tick = 0;
        check("R6 timeout again", irq_raw[1], 1);
        pop_rx(b); pop_rx(b);
        check("R6 empty clears", irq_raw[1], 0);
        char_tick = 1; step(); step(); step(); step(); char_tick = 0;
        push_rx(8'h03);
        check("R6 ticks while empty ignored", irq_raw[1], 0);
        pulse_clr_rx();
        load_cfg(8, 8, 12, 4);
    endtask

    task automatic t_mask();
        irq_enable = 8'h20; step();
        check("R9 masked view", irq_masked, 8'h20);
        check("R9 irq high", irq, 1);
        irq_enable = 8'h01; step();
        check("R9 masked empty", irq_masked, 8'h00);
        check("R9 irq low", irq, 0);
        irq_enable = 0;
    endtask

    task automatic t_cts();
        cts = 0; step(); step();
        check("R12 not yet after two edges", irq_raw[7], 0);
        step();
        check("R12 set after three edges", irq_raw[7], 1);
        irq_clr = 8'h80; step(); irq_clr = 0;
        check("R12 cts change cleared", irq_raw[7], 0);
    endtask

    task automatic t_clr_push();
        push_rx(8'h11); push_rx(8'h22);
        clr_rx = 1; rx_push = 1; rx_char = 8'h33; step(); clr_rx = 0; rx_push = 0;
        check("R10 clear beats push", rx_avail, 0);
    endtask

    initial begin
        repeat (4) step();
        rst = 0;
        step();
        t_reset();
        t_rx_order();
        t_rx_level();
        t_rx_ovf();
        t_tx();
        t_level_noclr();
        t_set_wins();
        t_rts();
        t_timeout();
        t_mask();
        t_cts();
        t_clr_push();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule